// File: doc/BRIEF.md
# Four-Bank Activation Timing Tracker

This block sits beside a DDR memory controller and watches the command stream it issues to a four-bank device. Each cycle it decodes the active-low chip-select and row/column/write strobes, works out whether the command obeys the bank state and the minimum spacings (row-to-column delay, activate-to-activate across banks, active-to-precharge, precharge recovery, and row cycle), and reports a one-cycle legal or illegal pulse with a cause code. All spacings are module parameters counted in clock cycles.

It keeps an open/idle state for every bank. A precharge with the A10 bit set closes all banks, and one with A10 clear closes only the addressed bank. A read or write with A10 set arms an internal auto-precharge. The tracker picks the cycle in which that precharge starts from the burst length, the write recovery time and the active-to-precharge minimum, and it flags that cycle per bank. It also produces a read-data window that follows the CAS latency and is cut short by a burst stop or a precharge of the reading bank.

Top module: `bank_timing_tracker`

## Requirements
- R1: A command is decoded only when cs_n is low. With {ras_n,cas_n,we_n} = 011 it is an activate, 101 a read, 100 a write, 010 a precharge, 110 a burst stop and 000 a mode write. Every other encoding, and any cycle with cs_n high, is a no-operation: it gives no result pulse and changes no state.
- R2: An activate is illegal with code 1 if the bank is open or has an auto-precharge pending. Otherwise it is illegal with code 6 if fewer than T_RP cycles have passed since the bank's precharge, then with code 7 if fewer than T_RC cycles have passed since the bank's last activate, then with code 4 if fewer than T_RRD cycles have passed since any legal activate. The codes are checked in that order.
- R3: A read or write is illegal with code 2 if the bank is idle or has an auto-precharge pending. Otherwise it is illegal with code 3 if fewer than T_RCD cycles have passed since the bank's activate.
- R4: A precharge with a10 high targets all banks and one with a10 low targets the bank on ba. It is illegal with code 5 if any targeted open bank was activated fewer than T_RAS cycles before. A legal precharge closes the targeted open banks. Precharging an idle bank is legal and changes nothing.
- R5: A mode write is illegal with code 1 while any bank is open, and with code 6 if any bank was precharged fewer than T_RP cycles before.
- R6: One cycle after each decoded non-NOP command, exactly one of cmd_ok and cmd_err pulses. err_code holds the cause with cmd_err and is 0 otherwise. An illegal command changes no bank state.
- R7: A legal read with a10 high starts the bank's precharge B cycles after the read, where B is the burst length in clock cycles. If the bank is still short of T_RAS cycles since its activate at that point, the start waits until T_RAS is met. In the cycle of the start, ap_start pulses for that bank and bank_open falls.
- R8: A legal write with a10 high starts its precharge B + 1 + T_WR cycles after the write, again no earlier than T_RAS after the activate.
- R9: rd_window is high for B cycles, beginning cl cycles after a legal read.
- R10: A burst stop is always legal. During a read it ends rd_window cl cycles after the stop. During a write it has no effect on bank state.
- R11: bl_code 2 selects 4 beats (B = 2), bl_code 3 selects 8 beats (B = 4), and any other value selects 2 beats (B = 1). cl gives the CAS latency in whole cycles, up to CL_MAX.
- R12: After reset, all banks are idle, no bank has an auto-precharge pending, and every timing window counts as already met.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| ba | input | BA_W | Bank address |
| a10 | input | 1 | Auto-precharge / all-banks bit |
| bl_code | input | 2 | Burst length select |
| cl | input | CL_W | CAS latency in cycles |
| bank_open | output | NB | Per-bank open flag |
| cmd_ok | output | 1 | Legal command pulse |
| cmd_err | output | 1 | Illegal command pulse |
| err_code | output | 3 | Cause of the illegal command |
| ap_start | output | NB | Per-bank auto-precharge start pulse |
| rd_window | output | 1 | Read data on the bus |

## Verification
The bench aims at commands placed exactly one cycle short of each spacing, and at commands that break two rules at once. A tracker with an off-by-one counter would accept these too early, and one that checks the rules in the wrong order would report the wrong cause code. It times an auto-precharge that has to wait for T_RAS and a write auto-precharge that does not. Starting the precharge at the burst end alone, or leaving out write recovery, shifts the ap_start pulse by a cycle or more. Burst stops during a read and during a write, a precharge of an idle bank, and a strobe pattern sent with chip select high check that a tracker does not close banks or cut the read window when it should not.

// File: rtl/bank_trk_pkg.sv
package bank_trk_pkg;

  typedef enum logic [2:0] {
    CMD_NOP, CMD_ACT, CMD_RD, CMD_WR, CMD_PRE, CMD_BST, CMD_MRS
  } cmd_e;

  typedef enum logic [2:0] {
    ERR_NONE = 3'd0,
    ERR_OPEN = 3'd1,
    ERR_IDLE = 3'd2,
    ERR_TRCD = 3'd3,
    ERR_TRRD = 3'd4,
    ERR_TRAS = 3'd5,
    ERR_TRP  = 3'd6,
    ERR_TRC  = 3'd7
  } err_e;

  function automatic cmd_e decode_cmd(input logic cs_n, input logic ras_n,
                                      input logic cas_n, input logic we_n);
    cmd_e c;
    c = CMD_NOP;
    if (!cs_n) begin
      case ({ras_n, cas_n, we_n})
        3'b011:  c = CMD_ACT;
        3'b101:  c = CMD_RD;
        3'b100:  c = CMD_WR;
        3'b010:  c = CMD_PRE;
        3'b110:  c = CMD_BST;
        3'b000:  c = CMD_MRS;
        default: c = CMD_NOP;
      endcase
    end
    return c;
  endfunction

endpackage

// File: rtl/bank_slot.sv
module bank_slot #(
  parameter int CNT_W = 6,
  parameter int T_RAS = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             act_i,
  input  logic             close_i,
  input  logic             arm_i,
  input  logic [CNT_W-1:0] delay_i,
  output logic             open_o,
  output logic             pend_o,
  output logic [CNT_W-1:0] act_age_o,
  output logic [CNT_W-1:0] pre_age_o,
  output logic             fire_o
);
  localparam logic [CNT_W-1:0] AGE_MAX = '1;
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  logic [CNT_W-1:0] wait_q;

  // The precharge starts once the burst delay has run out and tRAS is met.
  assign fire_o = pend_o && (wait_q <= ONE) && (act_age_o >= CNT_W'(T_RAS));

  always_ff @(posedge clk) begin
    if (rst) begin
      open_o    <= 1'b0;
      pend_o    <= 1'b0;
      wait_q    <= '0;
      act_age_o <= AGE_MAX;
      pre_age_o <= AGE_MAX;
    end else begin
      if (act_i) begin
        open_o    <= 1'b1;
        act_age_o <= ONE;
      end else if (act_age_o != AGE_MAX) begin
        act_age_o <= act_age_o + ONE;
      end

      if (fire_o || close_i) begin
        open_o    <= 1'b0;
        pre_age_o <= ONE;
      end else if (pre_age_o != AGE_MAX) begin
        pre_age_o <= pre_age_o + ONE;
      end

      if (arm_i) begin
        pend_o <= 1'b1;
        wait_q <= delay_i;
      end else if (fire_o) begin
        pend_o <= 1'b0;
        wait_q <= '0;
      end else if (pend_o && wait_q > ONE) begin
        wait_q <= wait_q - ONE;
      end
    end
  end
endmodule

// File: rtl/rd_window.sv
module rd_window #(
  parameter int CL_MAX = 3,
  parameter int BC_W   = 3,
  parameter int CL_W   = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_i,
  input  logic            kill_i,
  input  logic [BC_W-1:0] burst_i,
  input  logic [CL_W-1:0] cl_i,
  output logic            window_o
);
  logic [BC_W-1:0] left_q;
  logic [CL_MAX:0] slot_sr;
  logic            slot;
  logic [CL_W-1:0] tap;

  // Command-side burst slots, delayed by the CAS latency.
  assign slot = start_i | ((left_q != '0) & ~kill_i);
  assign tap  = (cl_i > CL_W'(CL_MAX)) ? CL_W'(CL_MAX) : cl_i;
  assign window_o = slot_sr[tap];

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q  <= '0;
      slot_sr <= '0;
    end else begin
      if (start_i)             left_q <= burst_i - BC_W'(1);
      else if (kill_i)         left_q <= '0;
      else if (left_q != '0)   left_q <= left_q - BC_W'(1);
      slot_sr <= {slot_sr[CL_MAX-1:0], slot};
    end
  end
endmodule

// File: rtl/bank_timing_tracker.sv
module bank_timing_tracker #(
  parameter int NB     = 4,
  parameter int T_RCD  = 3,
  parameter int T_RRD  = 2,
  parameter int T_RAS  = 6,
  parameter int T_RP   = 3,
  parameter int T_RC   = 10,
  parameter int T_WR   = 2,
  parameter int CL_MAX = 3,
  localparam int BA_W  = $clog2(NB),
  localparam int CL_W  = $clog2(CL_MAX + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cs_n,
  input  logic            ras_n,
  input  logic            cas_n,
  input  logic            we_n,
  input  logic [BA_W-1:0] ba,
  input  logic            a10,
  input  logic [1:0]      bl_code,
  input  logic [CL_W-1:0] cl,
  output logic [NB-1:0]   bank_open,
  output logic            cmd_ok,
  output logic            cmd_err,
  output logic [2:0]      err_code,
  output logic [NB-1:0]   ap_start,
  output logic            rd_window
);
  import bank_trk_pkg::*;

  localparam int CNT_W = $clog2(T_RC + T_RAS + T_RP + T_WR + T_RCD + T_RRD + 16) + 1;
  localparam int BC_W  = 3;
  localparam logic [CNT_W-1:0] AGE_MAX = '1;

  cmd_e             cmd;
  err_e             err;
  logic             legal;
  logic [NB-1:0]    tgt, pend_v, fire_v, open_v;
  logic [CNT_W-1:0] act_age [NB];
  logic [CNT_W-1:0] pre_age [NB];
  logic [CNT_W-1:0] rrd_age;
  logic [BC_W-1:0]  burst_cyc;
  logic [CNT_W-1:0] ap_delay;
  logic [BA_W-1:0]  rd_bank_q;
  logic             rd_go, rd_kill;

  assign cmd   = decode_cmd(cs_n, ras_n, cas_n, we_n);
  assign tgt   = a10 ? '1 : (NB'(1) << ba);
  assign legal = (err == ERR_NONE);

  always_comb begin
    case (bl_code)
      2'd2:    burst_cyc = BC_W'(2);
      2'd3:    burst_cyc = BC_W'(4);
      default: burst_cyc = BC_W'(1);
    endcase
  end

  assign ap_delay = (cmd == CMD_WR) ? CNT_W'(burst_cyc) + CNT_W'(1 + T_WR)
                                    : CNT_W'(burst_cyc);

  // Legality, in priority order within each command.
  always_comb begin
    err = ERR_NONE;
    case (cmd)
      CMD_ACT: begin
        if (open_v[ba])                            err = ERR_OPEN;
        else if (pre_age[ba] < CNT_W'(T_RP))       err = ERR_TRP;
        else if (act_age[ba] < CNT_W'(T_RC))       err = ERR_TRC;
        else if (rrd_age < CNT_W'(T_RRD))          err = ERR_TRRD;
      end
      CMD_RD, CMD_WR: begin
        if (!open_v[ba] || pend_v[ba])             err = ERR_IDLE;
        else if (act_age[ba] < CNT_W'(T_RCD))      err = ERR_TRCD;
      end
      CMD_PRE: begin
        for (int i = 0; i < NB; i++)
          if (tgt[i] && open_v[i] && !pend_v[i] && act_age[i] < CNT_W'(T_RAS))
            err = ERR_TRAS;
      end
      CMD_MRS: begin
        if (|open_v) err = ERR_OPEN;
        else
          for (int i = 0; i < NB; i++)
            if (pre_age[i] < CNT_W'(T_RP)) err = ERR_TRP;
      end
      default: err = ERR_NONE;
    endcase
  end

  genvar g;
  generate
    for (g = 0; g < NB; g++) begin : g_bank
      logic sel;
      assign sel = (ba == BA_W'(g));
      bank_slot #(.CNT_W(CNT_W), .T_RAS(T_RAS)) u_slot (
        .clk       (clk),
        .rst       (rst),
        .act_i     (legal && cmd == CMD_ACT && sel),
        .close_i   (legal && cmd == CMD_PRE && tgt[g] && open_v[g] && !pend_v[g]),
        .arm_i     (legal && (cmd == CMD_RD || cmd == CMD_WR) && a10 && sel),
        .delay_i   (ap_delay),
        .open_o    (open_v[g]),
        .pend_o    (pend_v[g]),
        .act_age_o (act_age[g]),
        .pre_age_o (pre_age[g]),
        .fire_o    (fire_v[g])
      );
    end
  endgenerate

  assign rd_go   = legal && (cmd == CMD_RD);
  assign rd_kill = (cmd == CMD_BST) || (legal && cmd == CMD_PRE && tgt[rd_bank_q]);

  rd_window #(.CL_MAX(CL_MAX), .BC_W(BC_W), .CL_W(CL_W)) u_rdwin (
    .clk      (clk),
    .rst      (rst),
    .start_i  (rd_go),
    .kill_i   (rd_kill),
    .burst_i  (burst_cyc),
    .cl_i     (cl),
    .window_o (rd_window)
  );

  assign bank_open = open_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      rrd_age   <= AGE_MAX;
      rd_bank_q <= '0;
      cmd_ok    <= 1'b0;
      cmd_err   <= 1'b0;
      err_code  <= 3'd0;
      ap_start  <= '0;
    end else begin
      if (legal && cmd == CMD_ACT)   rrd_age <= CNT_W'(1);
      else if (rrd_age != AGE_MAX)   rrd_age <= rrd_age + CNT_W'(1);
      if (rd_go) rd_bank_q <= ba;
      cmd_ok   <= (cmd != CMD_NOP) && legal;
      cmd_err  <= (cmd != CMD_NOP) && !legal;
      err_code <= (cmd != CMD_NOP) ? err : ERR_NONE;
      ap_start <= fire_v;
    end
  end
endmodule

// File: rtl/bank_trk_checker.sv
module bank_trk_checker #(
  parameter int NB   = 4,
  parameter int BA_W = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            cs_n,
  input logic            ras_n,
  input logic            cas_n,
  input logic            we_n,
  input logic [BA_W-1:0] ba,
  input logic            a10,
  input logic [NB-1:0]   bank_open,
  input logic            cmd_ok,
  input logic            cmd_err,
  input logic [2:0]      err_code,
  input logic [NB-1:0]   ap_start
);
  logic act_seen, pre_seen;
  assign act_seen = !cs_n && !ras_n && cas_n && we_n;
  assign pre_seen = !cs_n && !ras_n && cas_n && !we_n;

  genvar g;
  generate
    for (g = 0; g < NB; g++) begin : g_chk
      // R2: a bank only opens after an activate addressed to it
      a_r2_open_needs_act: assert property (@(posedge clk) disable iff (rst)
        $rose(bank_open[g]) |-> $past(act_seen && ba == BA_W'(g)));
      // R4: a bank only closes by a precharge aimed at it or by its auto-precharge
      a_r4_close_has_cause: assert property (@(posedge clk) disable iff (rst)
        $fell(bank_open[g]) |-> (ap_start[g] || $past(pre_seen && (a10 || ba == BA_W'(g)))));
      // R7: the auto-precharge pulse coincides with the bank closing
      a_r7_fire_closes: assert property (@(posedge clk) disable iff (rst)
        ap_start[g] |-> (!bank_open[g] && $past(bank_open[g])));
    end
  endgenerate

  // R6: results are exclusive, and an illegal command opens nothing
  a_r6_one_result: assert property (@(posedge clk) disable iff (rst)
    !(cmd_ok && cmd_err));
  a_r6_err_has_code: assert property (@(posedge clk) disable iff (rst)
    cmd_err |-> err_code != 3'd0);
  a_r6_err_opens_none: assert property (@(posedge clk) disable iff (rst)
    cmd_err |-> ((bank_open & ~$past(bank_open)) == '0));
endmodule

bind bank_timing_tracker bank_trk_checker #(.NB(NB), .BA_W(BA_W)) u_bank_trk_checker (
  .clk       (clk),
  .rst       (rst),
  .cs_n      (cs_n),
  .ras_n     (ras_n),
  .cas_n     (cas_n),
  .we_n      (we_n),
  .ba        (ba),
  .a10       (a10),
  .bank_open (bank_open),
  .cmd_ok    (cmd_ok),
  .cmd_err   (cmd_err),
  .err_code  (err_code),
  .ap_start  (ap_start)
);

// File: tb/test_bank_timing_tracker.sv
module test_bank_timing_tracker;
  localparam int C_NOP = 0, C_ACT = 1, C_RD = 2, C_WR = 3, C_PRE = 4, C_BST = 5, C_MRS = 6;
  localparam int OK = 0, E_OPEN = 1, E_IDLE = 2, E_TRCD = 3, E_TRRD = 4,
                 E_TRAS = 5, E_TRP = 6, E_TRC = 7;

  typedef struct {
    int    code;
    string req;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] ba = '0;
  logic       a10 = 1'b0;
  logic [1:0] bl_code = 2'd2;
  logic [1:0] cl = 2'd2;
  logic [3:0] bank_open, ap_start;
  logic       cmd_ok, cmd_err, rd_window;
  logic [2:0] err_code;

  int   n_run = 0, n_fail = 0;
  bit   done = 1'b0;
  exp_t sb[$];

  always #10 clk = ~clk;

  bank_timing_tracker i_bank_timing_tracker (
    .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .a10(a10), .bl_code(bl_code), .cl(cl), .bank_open(bank_open),
    .cmd_ok(cmd_ok), .cmd_err(cmd_err), .err_code(err_code), .ap_start(ap_start),
    .rd_window(rd_window)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  // Monitor: pops the expected result for every result pulse.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (!rst && (cmd_ok || cmd_err)) begin
        if (sb.size() == 0) begin
          check("R6 unexpected result", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          if (e.code == OK) check({e.req, " legal"}, {cmd_ok, cmd_err}, 2);
          else begin
            check({e.req, " illegal"}, {cmd_ok, cmd_err}, 1);
            check({e.req, " code"}, err_code, e.code);
          end
        end
      end
    end
  end

  // Driver: one command on the next edge, expected result queued.
  task automatic send(input int c, input int b, input bit ap, input int exp_code,
                      input string req);
    exp_t e;
    @(negedge clk);
    cs_n = 1'b0;
    case (c)
      C_ACT:   {ras_n, cas_n, we_n} = 3'b011;
      C_RD:    {ras_n, cas_n, we_n} = 3'b101;
      C_WR:    {ras_n, cas_n, we_n} = 3'b100;
      C_PRE:   {ras_n, cas_n, we_n} = 3'b010;
      C_BST:   {ras_n, cas_n, we_n} = 3'b110;
      C_MRS:   {ras_n, cas_n, we_n} = 3'b000;
      default: {ras_n, cas_n, we_n} = 3'b111;
    endcase
    ba  = 2'(b);
    a10 = ap;
    e.code = exp_code;
    e.req  = req;
    sb.push_back(e);
    @(posedge clk);
    #2;
    {cs_n, ras_n, cas_n, we_n} = 4'b1111;
    a10 = 1'b0;
  endtask

  task automatic wait_edges(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    check("watchdog", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    wait_edges(1);
    check("R12 reset open", bank_open, 0);
    check("R12 reset ap", ap_start, 0);
    check("R12 reset result", {cmd_ok, cmd_err}, 0);
    check("R12 reset window", rd_window, 0);

    send(C_RD,  0, 0, E_IDLE, "R3 read idle");
    check("R6 no state change", bank_open, 0);
    send(C_ACT, 0, 0, OK,     "R2 act");            // E0
    check("R2 open b0", bank_open, 4'b0001);
    send(C_ACT, 1, 0, E_TRRD, "R2 trrd");           // E0+1
    check("R6 trrd no open", bank_open, 4'b0001);
    send(C_ACT, 1, 0, OK,     "R2 act b1");         // E0+2
    send(C_RD,  1, 0, E_TRCD, "R3 trcd");           // E0+3
    send(C_RD,  0, 0, OK,     "R3 read b0");        // E0+4 = k
    send(C_PRE, 1, 0, E_TRAS, "R4 tras");           // k+1
    wait_edges(1); check("R9 window k+2", rd_window, 1);
    wait_edges(1); check("R9 window k+3", rd_window, 1);
    wait_edges(1); check("R9 window k+4", rd_window, 0);
    send(C_PRE, 2, 1, OK,     "R4 pre all");        // E0+9
    check("R4 all closed", bank_open, 0);
    send(C_ACT, 0, 0, E_TRP,  "R2 trp");            // E0+10
    send(C_MRS, 0, 0, E_TRP,  "R5 mrs trp");        // E0+11
    send(C_MRS, 0, 0, OK,     "R5 mrs");            // E0+12
    send(C_ACT, 0, 0, OK,     "R2 act F");          // F
    send(C_MRS, 0, 0, E_OPEN, "R5 mrs open");       // F+1
    send(C_ACT, 0, 0, E_OPEN, "R2 act open");       // F+2
    send(C_PRE, 2, 0, OK,     "R4 pre idle bank");  // F+3
    check("R4 idle pre no effect", bank_open, 4'b0001);
    send(C_PRE, 0, 0, E_TRAS, "R4 tras b0");        // F+4
    wait_edges(1);
    send(C_PRE, 0, 0, OK,     "R4 pre b0");         // F+6
    check("R4 single closed", bank_open, 0);
    wait_edges(2);
    send(C_ACT, 0, 0, E_TRC,  "R2 trc");            // F+9
    send(C_ACT, 0, 0, OK,     "R2 act G");          // G
    wait_edges(2);
    send(C_RD,  0, 1, OK,     "R7 read ap");        // G+3
    send(C_RD,  0, 0, E_IDLE, "R3 read pending");   // G+4
    wait_edges(1);
    check("R7 ap not yet", ap_start, 0);
    check("R7 still open", bank_open, 4'b0001);
    wait_edges(1);
    check("R7 ap at tras", ap_start, 4'b0001);
    check("R7 closed", bank_open, 0);
    send(C_ACT, 2, 0, OK,     "R2 act H");          // H = G+7
    wait_edges(2);
    send(C_WR,  2, 1, OK,     "R8 write ap");       // H+3
    wait_edges(4);
    check("R8 ap not yet", ap_start, 0);
    check("R8 still open", bank_open, 4'b0100);
    wait_edges(1);
    check("R8 ap start", ap_start, 4'b0100);
    check("R8 closed", bank_open, 0);
    wait_edges(1);
    check("R7 ap pulse", ap_start, 0);

    bl_code = 2'd3;
    send(C_ACT, 3, 0, OK,     "R2 act J");          // J
    wait_edges(2);
    send(C_RD,  3, 0, OK,     "R11 read bl8");      // k2
    send(C_BST, 0, 0, OK,     "R10 bst read");      // k2+1
    wait_edges(1); check("R10 window k2+2", rd_window, 1);
    wait_edges(1); check("R10 window cut", rd_window, 0);
    send(C_WR,  3, 0, OK,     "R10 write");
    send(C_BST, 0, 0, OK,     "R10 bst write");
    check("R10 bst write no effect", bank_open, 4'b1000);

    cl = 2'd3;
    bl_code = 2'd1;
    wait_edges(4);
    send(C_RD,  3, 0, OK,     "R11 read bl2");      // m
    wait_edges(2); check("R9 cl3 m+2", rd_window, 0);
    wait_edges(1); check("R9 cl3 m+3", rd_window, 1);
    wait_edges(1); check("R11 bl2 m+4", rd_window, 0);

    // R1: activate pattern with chip select high is ignored
    @(negedge clk);
    cs_n = 1'b1; {ras_n, cas_n, we_n} = 3'b011; ba = 2'd0;
    wait_edges(1);
    {ras_n, cas_n, we_n} = 3'b111;
    wait_edges(1);
    check("R1 deselected ignored", bank_open, 4'b1000);
    check("R1 no result", {cmd_ok, cmd_err}, 0);

    wait_edges(2);
    check("R6 scoreboard drained", sb.size(), 0);
    finish_run();
  end
endmodule